// File: doc/BRIEF.md
# Dual-Counter Real-Time Counter with Alarms

This block keeps time in a slow, always-on clock domain. A sub-second counter advances once per slow clock cycle, and each time it wraps from its all-ones value back to zero, the seconds counter advances on that same edge. Each counter has its own run bit, its own preset value and its own alarm compare value. Each alarm can raise its event in one of two ways: when the counter steps onto the alarm value, or on every step of the counter.

A processor on a much faster core clock reaches the block through a flat register port. A write aimed at the slow domain is held in a core-side holding register. It crosses to the slow domain through a toggle request and a returning toggle acknowledge, and two busy flags show whether a crossing is still open. The counter pair is sampled in the slow domain and passed across with its own toggle handshake, so a read always returns a second value and a sub-second value taken on the same slow edge.

Alarm events land in sticky status bits in the core domain. Writing ones to a clear register resets those bits one at a time. The interrupt line combines each status bit with its enable.

Top module: `rtm_dual_counter`

## Requirements
- R1: While the sub-second run bit (control bit 0) is set, the sub-second counter (SUB_W bits) advances by one on every slow clock edge and wraps from its all-ones value to 0.
- R2: A counter whose run bit is clear holds its value. The seconds run bit is control bit 1.
- R3: The seconds counter advances only on the slow edge where a running sub-second counter wraps, and only while the seconds run bit is set. A read pair from address 1 (sub-second) and address 2 (seconds) never shows time going backwards.
- R4: A write to address 1 or 2 presets that counter. The sub-second value keeps only its low SUB_W bits. After the write crosses, reading the same address returns the preset value while the counters are stopped.
- R5: A control write (address 0) with bit 4 set forces both counters to zero. Bit 4 always reads back as 0.
- R6: Address 3 holds the sub-second alarm and address 4 the seconds alarm. Control bits 5 and 6 select each alarm's mode. With mode 0 the event fires when the counter steps onto the alarm value. With mode 1 it fires on every step. Loading a counter fires no event.
- R7: A write to address 6 clears status bit 0 (sub-second) and/or bit 1 (seconds) wherever the written bit is 1, and leaves the other bit unchanged. An event arriving in the same cycle wins over the clear.
- R8: A status bit stays set until it is cleared, even after its interrupt enable is removed.
- R9: irq is high when status bit 0 is set together with control bit 2, or when status bit 1 is set together with control bit 3.
- R10: Status bit 3 (any write busy) rises in the cycle after an accepted write to addresses 0 to 4 and falls once the acknowledge returns. Status bit 2 does the same, but only for control writes. A write to addresses 0 to 4 made while bit 3 is set is ignored.
- R11: After reset, irq is low and the control, status and both counter reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| core_clk | input | 1 | Fast clock for the register port |
| rtc_clk | input | 1 | Slow timekeeping clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| reg_we | input | 1 | Write strobe for one core cycle |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq | output | 1 | Combined alarm interrupt |

## Verification
The bench builds the block with SUB_W = 4 and SEC_W = 32. With those values a sub-second lap lasts only 16 slow cycles, so wraps, seconds steps and seconds alarm matches happen within a few hundred core cycles, while the seconds path keeps its full width for large presets. The slow clock runs eight times slower than the core clock. That still leaves several core samples per slow edge for the toggle crossings and the sticky event path.

// File: rtl/rtm_pkg.sv
package rtm_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_SUB    = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_SEC    = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_SUBALM = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_SECALM = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_STAT   = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_ICLR   = 3'd6;

  // control bit positions; the two enables are adjacent
  localparam int CB_SUB_RUN  = 0;
  localparam int CB_SEC_RUN  = 1;
  localparam int CB_SUB_IE   = 2;
  localparam int CB_SEC_IE   = 3;
  localparam int CB_ZERO     = 4;
  localparam int CB_SUB_MODE = 5;
  localparam int CB_SEC_MODE = 6;
  localparam int CTRL_W      = 7;
endpackage

// File: rtl/rtm_sync_bit.sv
module rtm_sync_bit #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/rtm_rst_sync.sv
module rtm_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= 2'b00;
    else         sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_n_o = sh_q[1];
endmodule

// File: rtl/rtm_slow_core.sv
module rtm_slow_core
  import rtm_pkg::*;
#(
  parameter int SUB_W = 15,
  parameter int SEC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_s,
  input  logic [ADDR_W-1:0] hold_addr,
  input  logic [DATA_W-1:0] hold_data,
  output logic              ack_t,
  input  logic              snap_ack_s,
  output logic              snap_t,
  output logic [SUB_W-1:0]  snap_sub,
  output logic [SEC_W-1:0]  snap_sec,
  output logic              sub_evt_t,
  output logic              sec_evt_t,
  output logic [SUB_W-1:0]  sub_cnt,
  output logic [SEC_W-1:0]  sec_cnt,
  output logic              sub_run,
  output logic              sec_run,
  output logic              apply
);
  localparam logic [SUB_W-1:0] SUB_MAX = {SUB_W{1'b1}};

  logic             seen_q;
  logic             sub_run_q, sec_run_q, sub_mode_q, sec_mode_q;
  logic             sub_run_d, sec_run_d, sub_mode_d, sec_mode_d;
  logic [SUB_W-1:0] sub_q, sub_d, sub_alm_q, sub_alm_d, sub_inc;
  logic [SEC_W-1:0] sec_q, sec_d, sec_alm_q, sec_alm_d, sec_inc;
  logic             sub_hit, sec_hit, sub_wrap;
  logic             snap_t_q, snap_t_d, snap_go;
  logic [SUB_W-1:0] snap_sub_q, snap_sub_d;
  logic [SEC_W-1:0] snap_sec_q, snap_sec_d;
  logic             sub_et_q, sec_et_q;

  always_comb begin
    apply      = (req_s != seen_q);
    sub_run_d  = sub_run_q;
    sec_run_d  = sec_run_q;
    sub_mode_d = sub_mode_q;
    sec_mode_d = sec_mode_q;
    sub_alm_d  = sub_alm_q;
    sec_alm_d  = sec_alm_q;
    sub_inc    = sub_q + 1'b1;
    sec_inc    = sec_q + 1'b1;
    sub_wrap   = sub_run_q && (sub_q == SUB_MAX);
    sub_d      = sub_run_q ? sub_inc : sub_q;
    sec_d      = (sec_run_q && sub_wrap) ? sec_inc : sec_q;
    sub_hit    = sub_run_q && (sub_mode_q || (sub_inc == sub_alm_q));
    sec_hit    = sec_run_q && sub_wrap && (sec_mode_q || (sec_inc == sec_alm_q));
    if (apply) begin
      case (hold_addr)
        ADR_CTRL: begin
          sub_run_d  = hold_data[CB_SUB_RUN];
          sec_run_d  = hold_data[CB_SEC_RUN];
          sub_mode_d = hold_data[CB_SUB_MODE];
          sec_mode_d = hold_data[CB_SEC_MODE];
          if (hold_data[CB_ZERO]) begin
            sub_d   = '0;
            sec_d   = '0;
            sub_hit = 1'b0;
            sec_hit = 1'b0;
          end
        end
        ADR_SUB: begin
          sub_d   = hold_data[SUB_W-1:0];
          sub_hit = 1'b0;
        end
        ADR_SEC: begin
          sec_d   = hold_data[SEC_W-1:0];
          sec_hit = 1'b0;
        end
        ADR_SUBALM: sub_alm_d = hold_data[SUB_W-1:0];
        ADR_SECALM: sec_alm_d = hold_data[SEC_W-1:0];
        default: ;
      endcase
    end
    // sample a coherent pair once the core has taken the previous one
    snap_go    = (snap_ack_s == snap_t_q);
    snap_t_d   = snap_go ? ~snap_t_q : snap_t_q;
    snap_sub_d = snap_go ? sub_q : snap_sub_q;
    snap_sec_d = snap_go ? sec_q : snap_sec_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q     <= 1'b0;
      sub_run_q  <= 1'b0;
      sec_run_q  <= 1'b0;
      sub_mode_q <= 1'b0;
      sec_mode_q <= 1'b0;
      sub_alm_q  <= '0;
      sec_alm_q  <= '0;
      sub_q      <= '0;
      sec_q      <= '0;
      snap_t_q   <= 1'b0;
      snap_sub_q <= '0;
      snap_sec_q <= '0;
      sub_et_q   <= 1'b0;
      sec_et_q   <= 1'b0;
    end else begin
      seen_q     <= req_s;
      sub_run_q  <= sub_run_d;
      sec_run_q  <= sec_run_d;
      sub_mode_q <= sub_mode_d;
      sec_mode_q <= sec_mode_d;
      sub_alm_q  <= sub_alm_d;
      sec_alm_q  <= sec_alm_d;
      sub_q      <= sub_d;
      sec_q      <= sec_d;
      snap_t_q   <= snap_t_d;
      snap_sub_q <= snap_sub_d;
      snap_sec_q <= snap_sec_d;
      sub_et_q   <= sub_et_q ^ sub_hit;
      sec_et_q   <= sec_et_q ^ sec_hit;
    end
  end

  assign ack_t     = seen_q;
  assign snap_t    = snap_t_q;
  assign snap_sub  = snap_sub_q;
  assign snap_sec  = snap_sec_q;
  assign sub_evt_t = sub_et_q;
  assign sec_evt_t = sec_et_q;
  assign sub_cnt   = sub_q;
  assign sec_cnt   = sec_q;
  assign sub_run   = sub_run_q;
  assign sec_run   = sec_run_q;
endmodule

// File: rtl/rtm_host_regs.sv
module rtm_host_regs
  import rtm_pkg::*;
#(
  parameter int SUB_W = 15,
  parameter int SEC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic [ADDR_W-1:0] hold_addr,
  output logic [DATA_W-1:0] hold_data,
  output logic              req_t,
  input  logic              ack_s,
  input  logic              snap_t_s,
  input  logic [SUB_W-1:0]  snap_sub,
  input  logic [SEC_W-1:0]  snap_sec,
  output logic              snap_ack,
  input  logic              sub_evt_s,
  input  logic              sec_evt_s,
  output logic [1:0]        stat,
  output logic [1:0]        stat_set,
  output logic [1:0]        stat_clr,
  output logic              ctrl_busy,
  output logic              any_busy
);
  logic              pend_q, pend_d, req_q, accept;
  logic [ADDR_W-1:0] haddr_q;
  logic [DATA_W-1:0] hdata_q;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [1:0]        stat_q, stat_d, evt_prev_q;
  logic              sack_q, take;
  logic [SUB_W-1:0]  cur_sub_q;
  logic [SEC_W-1:0]  cur_sec_q;

  always_comb begin
    accept   = reg_we && (reg_addr <= ADR_SECALM) && !pend_q;
    pend_d   = pend_q;
    if (accept)                       pend_d = 1'b1;
    else if (pend_q && ack_s == req_q) pend_d = 1'b0;
    ctrl_d   = ctrl_q;
    if (accept && reg_addr == ADR_CTRL) begin
      ctrl_d          = reg_wdata[CTRL_W-1:0];
      ctrl_d[CB_ZERO] = 1'b0;
    end
    stat_set = {sec_evt_s, sub_evt_s} ^ evt_prev_q;
    stat_clr = (reg_we && reg_addr == ADR_ICLR) ? reg_wdata[1:0] : 2'b00;
    stat_d   = (stat_q & ~stat_clr) | stat_set;
    take     = (snap_t_s != sack_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      req_q      <= 1'b0;
      haddr_q    <= '0;
      hdata_q    <= '0;
      ctrl_q     <= '0;
      stat_q     <= '0;
      evt_prev_q <= '0;
      sack_q     <= 1'b0;
      cur_sub_q  <= '0;
      cur_sec_q  <= '0;
    end else begin
      pend_q     <= pend_d;
      req_q      <= req_q ^ accept;
      ctrl_q     <= ctrl_d;
      stat_q     <= stat_d;
      evt_prev_q <= {sec_evt_s, sub_evt_s};
      if (accept) begin
        haddr_q <= reg_addr;
        hdata_q <= reg_wdata;
      end
      if (take) begin
        sack_q    <= snap_t_s;
        cur_sub_q <= snap_sub;
        cur_sec_q <= snap_sec;
      end
    end
  end

  assign ctrl_busy = pend_q && (haddr_q == ADR_CTRL);
  assign any_busy  = pend_q;
  assign irq       = |(stat_q & {ctrl_q[CB_SEC_IE], ctrl_q[CB_SUB_IE]});

  always_comb begin
    case (reg_addr)
      ADR_CTRL: reg_rdata = DATA_W'(ctrl_q);
      ADR_SUB:  reg_rdata = DATA_W'(cur_sub_q);
      ADR_SEC:  reg_rdata = DATA_W'(cur_sec_q);
      ADR_STAT: reg_rdata = DATA_W'({any_busy, ctrl_busy, stat_q});
      default:  reg_rdata = '0;
    endcase
  end

  assign hold_addr = haddr_q;
  assign hold_data = hdata_q;
  assign req_t     = req_q;
  assign snap_ack  = sack_q;
  assign stat      = stat_q;
endmodule

// File: rtl/rtm_dual_counter.sv
module rtm_dual_counter
  import rtm_pkg::*;
#(
  parameter int SUB_W = 15,
  parameter int SEC_W = 32
) (
  input  logic              core_clk,
  input  logic              rtc_clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic              core_rst_n, rtc_rst_n;
  logic [ADDR_W-1:0] hold_addr;
  logic [DATA_W-1:0] hold_data;
  logic              req_t, req_s, ack_t, ack_s;
  logic              snap_t, snap_t_s, snap_ack, snap_ack_s;
  logic [SUB_W-1:0]  snap_sub, sub_cnt;
  logic [SEC_W-1:0]  snap_sec, sec_cnt;
  logic              sub_evt_t, sec_evt_t, sub_evt_s, sec_evt_s;
  logic              sub_run, sec_run, apply;
  logic [1:0]        stat, stat_set, stat_clr;
  logic              ctrl_busy, any_busy;

  rtm_rst_sync u_rst_core (.clk(core_clk), .arst_n(rst_n), .rst_n_o(core_rst_n));
  rtm_rst_sync u_rst_rtc  (.clk(rtc_clk),  .arst_n(rst_n), .rst_n_o(rtc_rst_n));

  rtm_sync_bit #(.WIDTH(2)) u_to_rtc (
    .clk(rtc_clk), .rst_n(rtc_rst_n),
    .d({snap_ack, req_t}), .q({snap_ack_s, req_s})
  );

  rtm_sync_bit #(.WIDTH(4)) u_to_core (
    .clk(core_clk), .rst_n(core_rst_n),
    .d({sec_evt_t, sub_evt_t, snap_t, ack_t}),
    .q({sec_evt_s, sub_evt_s, snap_t_s, ack_s})
  );

  rtm_slow_core #(.SUB_W(SUB_W), .SEC_W(SEC_W)) u_slow (
    .clk(rtc_clk), .rst_n(rtc_rst_n),
    .req_s(req_s), .hold_addr(hold_addr), .hold_data(hold_data), .ack_t(ack_t),
    .snap_ack_s(snap_ack_s), .snap_t(snap_t), .snap_sub(snap_sub), .snap_sec(snap_sec),
    .sub_evt_t(sub_evt_t), .sec_evt_t(sec_evt_t),
    .sub_cnt(sub_cnt), .sec_cnt(sec_cnt), .sub_run(sub_run), .sec_run(sec_run),
    .apply(apply)
  );

  rtm_host_regs #(.SUB_W(SUB_W), .SEC_W(SEC_W)) u_host (
    .clk(core_clk), .rst_n(core_rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .hold_addr(hold_addr), .hold_data(hold_data), .req_t(req_t), .ack_s(ack_s),
    .snap_t_s(snap_t_s), .snap_sub(snap_sub), .snap_sec(snap_sec), .snap_ack(snap_ack),
    .sub_evt_s(sub_evt_s), .sec_evt_s(sec_evt_s),
    .stat(stat), .stat_set(stat_set), .stat_clr(stat_clr),
    .ctrl_busy(ctrl_busy), .any_busy(any_busy)
  );
endmodule

// File: rtl/rtm_dual_counter_chk.sv
module rtm_dual_counter_chk #(
  parameter int SUB_W = 15,
  parameter int SEC_W = 32
) (
  input logic             rtc_clk,
  input logic             rtc_rst_n,
  input logic             core_clk,
  input logic             core_rst_n,
  input logic [SUB_W-1:0] sub_cnt,
  input logic [SEC_W-1:0] sec_cnt,
  input logic             sub_run,
  input logic             sec_run,
  input logic             apply,
  input logic [1:0]       stat,
  input logic [1:0]       stat_set,
  input logic [1:0]       stat_clr,
  input logic             ctrl_busy,
  input logic             any_busy
);
  localparam logic [SUB_W-1:0] SUB_MAX = {SUB_W{1'b1}};

  assert_sub_step_R1: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
    (sub_run && !apply) |=> (sub_cnt == SUB_W'($past(sub_cnt) + 1'b1)));

  assert_sub_hold_R2: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
    (!sub_run && !apply) |=> $stable(sub_cnt));

  assert_sec_on_wrap_R3: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
    (sub_run && sec_run && sub_cnt == SUB_MAX && !apply) |=>
      (sec_cnt == SEC_W'($past(sec_cnt) + 1'b1)));

  assert_sec_only_on_wrap_R3: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
    (!(sub_run && sub_cnt == SUB_MAX) && !apply) |=> $stable(sec_cnt));

  assert_clear_sub_R7: assert property (@(posedge core_clk) disable iff (!core_rst_n)
    (stat_clr[0] && !stat_set[0]) |=> !stat[0]);

  assert_clear_sec_R7: assert property (@(posedge core_clk) disable iff (!core_rst_n)
    (stat_clr[1] && !stat_set[1]) |=> !stat[1]);

  assert_sticky_R8: assert property (@(posedge core_clk) disable iff (!core_rst_n)
    (stat[0] && !stat_clr[0]) |=> stat[0]);

  assert_busy_nest_R10: assert property (@(posedge core_clk) disable iff (!core_rst_n)
    ctrl_busy |-> any_busy);
endmodule

bind rtm_dual_counter rtm_dual_counter_chk #(.SUB_W(SUB_W), .SEC_W(SEC_W)) u_chk (
  .rtc_clk(rtc_clk), .rtc_rst_n(rtc_rst_n), .core_clk(core_clk), .core_rst_n(core_rst_n),
  .sub_cnt(sub_cnt), .sec_cnt(sec_cnt), .sub_run(sub_run), .sec_run(sec_run),
  .apply(apply), .stat(stat), .stat_set(stat_set), .stat_clr(stat_clr),
  .ctrl_busy(ctrl_busy), .any_busy(any_busy)
);

// File: tb/rtm_dual_counter_tb.sv
module rtm_dual_counter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RTC_PERIOD = 80;
  localparam int SUB_W = 4;
  localparam int SEC_W = 32;

  logic        core_clk = 1'b0, rtc_clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        irq;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) core_clk = ~core_clk;
  always #(RTC_PERIOD/2) rtc_clk = ~rtc_clk;

  rtm_dual_counter #(.SUB_W(SUB_W), .SEC_W(SEC_W)) u_dut (
    .core_clk(core_clk), .rtc_clk(rtc_clk), .rst_n(rst_n), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // {seconds preset, sub-second write, expected sub-second readback}
  localparam logic [31:0] PRESETS [4][3] = '{
    '{32'h1234_5678, 32'h3,  32'h3},
    '{32'hFFFF_FFFF, 32'hF,  32'hF},
    '{32'h0,         32'h1F, 32'hF},
    '{32'hA5,        32'h10, 32'h0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge core_clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge core_clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 1000; i++) begin
      rd(3'd5, s);
      if (!s[3]) break;
      @(negedge core_clk);
    end
  endtask

  task automatic rtc_wait(input int n);
    repeat (n) @(posedge rtc_clk);
    @(negedge core_clk);
  endtask

  task automatic wr_idle(input logic [2:0] a, input logic [31:0] d);
    wr(a, d);
    wait_idle();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge core_clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v, s, sc, st;
    longint prev, cur;
    repeat (5) @(negedge core_clk);
    rst_n = 1'b1;
    rtc_wait(12);

    // R11 reset state
    chk("R11 irq", {31'd0, irq}, 32'd0);
    rd(3'd5, v); chk("R11 status", v, 0);
    rd(3'd0, v); chk("R11 ctrl", v, 0);
    rd(3'd1, v); chk("R11 sub", v, 0);
    rd(3'd2, v); chk("R11 sec", v, 0);

    // R10 busy flags and write while busy
    wr(3'd1, 32'd3);
    rd(3'd5, v); chk("R10 busy after preset", {30'd0, v[3:2]}, 32'd2);
    wr(3'd1, 32'd9);
    wait_idle();
    rd(3'd5, v); chk("R10 busy cleared", {30'd0, v[3:2]}, 32'd0);
    rtc_wait(12);
    rd(3'd1, v); chk("R10 write while busy ignored", v, 32'd3);
    wr(3'd0, 32'd0);
    rd(3'd5, v); chk("R10 busy after ctrl", {30'd0, v[3:2]}, 32'd3);
    wait_idle();

    // R4 preset table
    foreach (PRESETS[i]) begin
      wr_idle(3'd2, PRESETS[i][0]);
      wr_idle(3'd1, PRESETS[i][1]);
      rtc_wait(12);
      rd(3'd2, v); chk("R4 sec preset", v, PRESETS[i][0]);
      rd(3'd1, v); chk("R4 sub preset", v, PRESETS[i][2]);
    end

    // R5 zero bit
    wr_idle(3'd0, 32'h3);
    rtc_wait(20);
    wr_idle(3'd0, 32'h10);
    rtc_wait(12);
    rd(3'd1, v); chk("R5 sub zeroed", v, 0);
    rd(3'd2, v); chk("R5 sec zeroed", v, 0);
    rd(3'd0, v); chk("R5 zero bit reads 0", v, 0);

    // R3 coherence while both run
    wr_idle(3'd2, 32'h40);
    wr_idle(3'd0, 32'h3);
    prev = 0;
    for (int i = 0; i < 60; i++) begin
      rtc_wait(3);
      rd(3'd1, s); rd(3'd2, sc);
      cur = longint'(sc) * 16 + longint'(s);
      if (cur < prev) chk("R3 time went backwards", 32'(cur), 32'(prev));
      else            chk("R3 monotonic", 0, 0);
      prev = cur;
    end
    rd(3'd2, v); chk("R3 seconds advanced", {31'd0, v > 32'h40}, 32'd1);

    // R1 single wrap steps seconds once
    wr_idle(3'd0, 32'h0);
    wr_idle(3'd2, 32'd100);
    wr_idle(3'd1, 32'd13);
    wr_idle(3'd0, 32'h3);
    rtc_wait(8);
    wr_idle(3'd0, 32'h0);
    rtc_wait(12);
    rd(3'd2, v); chk("R1 wrap steps seconds once", v, 32'd101);
    rd(3'd1, v); chk("R1 sub after wrap in range", {31'd0, v >= 6 && v <= 12}, 32'd1);

    // R2 seconds held while only sub runs
    wr_idle(3'd2, 32'd7);
    wr_idle(3'd0, 32'h1);
    rtc_wait(40);
    wr_idle(3'd0, 32'h0);
    rtc_wait(12);
    rd(3'd2, v); chk("R2 sec held", v, 32'd7);
    rd(3'd1, s); rtc_wait(10); rd(3'd1, v); chk("R2 stopped sub held", v, s);

    // R6 sub match mode
    wr_idle(3'd1, 32'd0);
    wr_idle(3'd3, 32'd12);
    wr(3'd6, 32'h3);
    rtc_wait(6);
    wr_idle(3'd0, 32'h5);
    rtc_wait(6);
    rd(3'd5, v); chk("R6 no match before alarm", {31'd0, v[0]}, 0);
    chk("R9 irq low without status", {31'd0, irq}, 0);
    rtc_wait(10);
    rd(3'd5, v); chk("R6 match sets sub status", {31'd0, v[0]}, 1);
    chk("R9 irq with status and enable", {31'd0, irq}, 1);

    // R8 sticky after enable removed
    wr_idle(3'd0, 32'h1);
    rtc_wait(2);
    chk("R9 irq low after enable removed", {31'd0, irq}, 0);
    rd(3'd5, v); chk("R8 status sticky", {31'd0, v[0]}, 1);

    // R7 clear while stopped, then R6 increment mode
    wr_idle(3'd0, 32'h0);
    rtc_wait(6);
    wr(3'd6, 32'h1);
    rtc_wait(6);
    rd(3'd5, v); chk("R7 cleared stays clear", {31'd0, v[0]}, 0);
    wr_idle(3'd1, 32'd0);
    wr_idle(3'd0, 32'h21);
    rtc_wait(3);
    rd(3'd5, v); chk("R6 increment mode fires", {31'd0, v[0]}, 1);

    // R6 seconds match
    wr_idle(3'd0, 32'h0);
    wr_idle(3'd1, 32'd0);
    wr_idle(3'd2, 32'd0);
    wr_idle(3'd4, 32'd2);
    wr(3'd6, 32'h3);
    rtc_wait(4);
    wr_idle(3'd0, 32'hB);
    rtc_wait(20);
    rd(3'd5, v); chk("R6 no sec event at first second", {31'd0, v[1]}, 0);
    rtc_wait(14);
    rd(3'd5, v); chk("R6 sec match fires", {31'd0, v[1]}, 1);
    chk("R9 irq from seconds", {31'd0, irq}, 1);

    // R7 independent clears
    wr_idle(3'd0, 32'h0);
    rtc_wait(6);
    rd(3'd5, st); chk("R7 both set before clear", {30'd0, st[1:0]}, 3);
    wr(3'd6, 32'h1);
    rd(3'd5, v); chk("R7 clear sub only", {30'd0, v[1:0]}, 2);
    wr(3'd6, 32'h2);
    rd(3'd5, v); chk("R7 clear sec", {30'd0, v[1:0]}, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule